// File: doc/BRIEF.md
# Masked Pin Pattern Watcher

This block watches two 8-bit groups of input pins and flags when the pins no longer hold the level pattern software expects. Each group has an expected-level register and an include mask. Only the pins whose mask bit is 1 take part in the compare. A difference on either group produces one combined mismatch indication. The compare uses the raw pin levels, after a two-flop synchroniser, whatever the pins are otherwise routed to.

The combined result drives three outputs:
- A registered mismatch level.
- A sticky interrupt flag. It sets on a rising mismatch while interrupts are enabled, and software clears it by writing 1.
- A wake request for a power controller. It is taken straight from the synchronised compare and gated only by its own enable.

Software reaches all the registers through a small strobe-based bus. Reads return their data one cycle after the read strobe.

Top module: `pin_pattern_watch`

## Requirements
- R1: After reset, both expected-level registers (addresses 0 and 2) read 0xFF. Both masks (addresses 1 and 3) read 0x00. The control register reads 0x00. mismatch_o, irq_o and wake_o are all 0.
- R2: The register map is as follows.
  - Address 0: group A expected levels.
  - Address 1: group A mask.
  - Address 2: group B expected levels.
  - Address 3: group B mask.
  - Address 4: control. Bit 0 is the interrupt enable and bit 1 is the wake enable.
  - Address 5: status. Bit 0 is the flag and bit 1 is the mismatch level.
  - Other addresses read 0.
  A read strobe at one clock edge places the data on bus_rdata_o after that edge, and the data holds until the next read.
- R3: A mismatch exists when ((pins_A ^ expect_A) & mask_A) != 0 or ((pins_B ^ expect_B) & mask_B) != 0. The results of the two groups are ORed together.
- R4: A pin whose mask bit is 0 has no effect on mismatch_o, irq_o or wake_o.
- R5: A pin change is first seen by wake_o after two clock edges, and by mismatch_o after three.
- R6: irq_o sets at the same edge at which mismatch_o rises, provided the interrupt enable was 1.
- R7: irq_o stays set until a write of 1 to status bit 0. The clear wins over a set in the same cycle.
- R8: wake_o equals (wake enable AND the combined compare on the synchronised pins). It does not depend on the interrupt enable or on the flag.
- R9: A write to an expected-level or mask register changes the compare right after the write edge. A mismatch created only by such a write sets the flag in the same way as a pin change.
- R10: A mismatch that rises while the interrupt enable is 0 never sets irq_o. The wake request still follows the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_a_i | input | 8 | Group A pin levels (asynchronous) |
| port_b_i | input | 8 | Group B pin levels (asynchronous) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid after a read edge |
| mismatch_o | output | 1 | Registered combined mismatch level |
| irq_o | output | 1 | Sticky interrupt flag |
| wake_o | output | 1 | Wake request to the power controller |

## Verification
Some properties are checked by the assertions on every cycle:
- The flag rises only together with a rising mismatch level while the interrupt is enabled.
- The flag holds until a clear, and a clear always wins.
- The wake request is silent when its enable is off, and it is always followed one edge later by the mismatch level.
- An all-zero mask keeps the level low.

Other behaviours only the bench's scenarios and its per-cycle reference model can show:
- The exact synchroniser latency.
- The masked compare on each group.
- The readback values.
- The clear landing on the very edge of a write-induced rise.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
    localparam int PIN_W  = 8;
    localparam int NPORT  = 2;
    localparam int ADDR_W = 3;
    localparam int DATA_W = PIN_W;

    // per-group registers sit at 2*g (expected) and 2*g+1 (mask)
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2 * NPORT);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 * NPORT + 1);

    localparam int CTRL_IRQ_BIT  = 0;
    localparam int CTRL_WAKE_BIT = 1;
    localparam int STAT_FLAG_BIT = 0;
    localparam int STAT_LVL_BIT  = 1;

    typedef logic [PIN_W-1:0] pin_vec_t;

    typedef struct packed {
        pin_vec_t [NPORT-1:0] expect_lv;
        pin_vec_t [NPORT-1:0] mask;
        logic                 irq_en;
        logic                 wake_en;
    } cfg_t;

    typedef struct packed {
        cfg_t              cfg;
        logic [DATA_W-1:0] rdata;
    } regs_st_t;

    typedef struct packed {
        logic level;
        logic flag;
    } evt_st_t;
endpackage

// File: rtl/pw_sync.sv
`timescale 1ns/1ps
module pw_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb chain_d[s] = async_i;
            end else begin : g_next
                always_comb chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pw_regs.sv
`timescale 1ns/1ps
module pw_regs
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              level_i,
    input  logic              flag_i,
    output cfg_t              cfg_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              clr_o
);
    regs_st_t st_d, st_q;

    function automatic regs_st_t reset_state();
        regs_st_t r;
        r = '0;
        for (int g = 0; g < NPORT; g++) begin
            r.cfg.expect_lv[g] = '1;
            r.cfg.mask[g]      = '0;
        end
        return r;
    endfunction

    always_comb begin
        st_d  = st_q;
        clr_o = 1'b0;
        if (rd_i) begin
            st_d.rdata = '0;
            for (int g = 0; g < NPORT; g++) begin
                if (addr_i == ADDR_W'(2 * g))     st_d.rdata = st_q.cfg.expect_lv[g];
                if (addr_i == ADDR_W'(2 * g + 1)) st_d.rdata = st_q.cfg.mask[g];
            end
            if (addr_i == A_CTRL) begin
                st_d.rdata[CTRL_IRQ_BIT]  = st_q.cfg.irq_en;
                st_d.rdata[CTRL_WAKE_BIT] = st_q.cfg.wake_en;
            end
            if (addr_i == A_STAT) begin
                st_d.rdata[STAT_FLAG_BIT] = flag_i;
                st_d.rdata[STAT_LVL_BIT]  = level_i;
            end
        end
        if (wr_i) begin
            for (int g = 0; g < NPORT; g++) begin
                if (addr_i == ADDR_W'(2 * g))     st_d.cfg.expect_lv[g] = wdata_i;
                if (addr_i == ADDR_W'(2 * g + 1)) st_d.cfg.mask[g]      = wdata_i;
            end
            if (addr_i == A_CTRL) begin
                st_d.cfg.irq_en  = wdata_i[CTRL_IRQ_BIT];
                st_d.cfg.wake_en = wdata_i[CTRL_WAKE_BIT];
            end
            if (addr_i == A_STAT) clr_o = wdata_i[STAT_FLAG_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign cfg_o   = st_q.cfg;
    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/pw_compare.sv
`timescale 1ns/1ps
module pw_compare
    import pw_pkg::*;
(
    input  pin_vec_t [NPORT-1:0] pins_i,
    input  cfg_t                 cfg_i,
    output logic                 miss_o
);
    logic [NPORT-1:0] group_miss;

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_grp
            assign group_miss[g] = |((pins_i[g] ^ cfg_i.expect_lv[g]) & cfg_i.mask[g]);
        end
    endgenerate

    assign miss_o = |group_miss;
endmodule

// File: rtl/pw_event.sv
`timescale 1ns/1ps
module pw_event
    import pw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_i,
    input  logic irq_en_i,
    input  logic clr_i,
    output logic level_o,
    output logic flag_o
);
    evt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = miss_i;
        if (clr_i)                                  st_d.flag = 1'b0;
        else if (irq_en_i && miss_i && !st_q.level) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
    assign flag_o  = st_q.flag;
endmodule

// File: rtl/pin_pattern_watch.sv
`timescale 1ns/1ps
module pin_pattern_watch
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  port_a_i,
    input  logic [PIN_W-1:0]  port_b_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              mismatch_o,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int SYNC_W = PIN_W * NPORT;

    logic [SYNC_W-1:0]    raw_pins, sync_pins;
    pin_vec_t [NPORT-1:0] pins;
    cfg_t                 cfg;
    logic                 miss_now, level, flag, clr;

    assign raw_pins = {port_b_i, port_a_i};
    assign pins     = sync_pins;

    pw_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_pins), .sync_o(sync_pins)
    );

    pw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
        .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .level_i(level),
        .flag_i(flag), .cfg_o(cfg), .rdata_o(bus_rdata_o), .clr_o(clr)
    );

    pw_compare u_cmp (.pins_i(pins), .cfg_i(cfg), .miss_o(miss_now));

    pw_event u_evt (
        .clk(clk), .rst_n(rst_n), .miss_i(miss_now), .irq_en_i(cfg.irq_en),
        .clr_i(clr), .level_o(level), .flag_o(flag)
    );

    assign mismatch_o = level;
    assign irq_o      = flag;
    assign wake_o     = cfg.wake_en & miss_now;
endmodule

// File: rtl/pw_check.sv
`timescale 1ns/1ps
module pw_check
    import pw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              mismatch_o,
    input logic              irq_o,
    input logic              wake_o,
    input cfg_t              cfg
);
    logic clr_req;
    assign clr_req = bus_wr_i && (bus_addr_i == A_STAT) && bus_wdata_i[STAT_FLAG_BIT];

    p_irq_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (mismatch_o && !$past(mismatch_o) && $past(cfg.irq_en)));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_req) |=> irq_o);

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !irq_o);

    p_wake_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.wake_en |-> !wake_o);

    p_wake_leads_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> mismatch_o);

    p_no_mask_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mask == '0) |=> !mismatch_o);

    p_no_flag_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.irq_en && !irq_o) |=> !irq_o);
endmodule

bind pin_pattern_watch pw_check u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .mismatch_o(mismatch_o), .irq_o(irq_o),
    .wake_o(wake_o), .cfg(cfg)
);

// File: tb/pin_pattern_watch_test.sv
`timescale 1ns/1ps
module pin_pattern_watch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_a = 8'h00, port_b = 8'h00;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       mismatch, irq, wake;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pin_pattern_watch uut (
        .clk(clk), .rst_n(rst_n), .port_a_i(port_a), .port_b_i(port_b),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .mismatch_o(mismatch), .irq_o(irq), .wake_o(wake)
    );

    // behavioural reference model
    logic [7:0] m_exp [2];
    logic [7:0] m_msk [2];
    bit         m_ien, m_wen, m_lvl, m_flag;
    logic [7:0] m_rd;
    logic [7:0] qa[$], qb[$];

    function automatic bit m_miss();
        bit r = 0;
        if (((qa[0] ^ m_exp[0]) & m_msk[0]) != 8'h00) r = 1;
        if (((qb[0] ^ m_exp[1]) & m_msk[1]) != 8'h00) r = 1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_exp[0] = 8'hFF; m_exp[1] = 8'hFF; m_msk[0] = 8'h00; m_msk[1] = 8'h00;
            m_ien = 0; m_wen = 0; m_lvl = 0; m_flag = 0; m_rd = 8'h00;
            qa = '{8'h00, 8'h00}; qb = '{8'h00, 8'h00};
        end else begin
            bit now_miss, clr;
            now_miss = m_miss();
            if (bus_rd) begin
                case (bus_addr)
                    3'd0: m_rd = m_exp[0];
                    3'd1: m_rd = m_msk[0];
                    3'd2: m_rd = m_exp[1];
                    3'd3: m_rd = m_msk[1];
                    3'd4: m_rd = {6'd0, m_wen, m_ien};
                    3'd5: m_rd = {6'd0, m_lvl, m_flag};
                    default: m_rd = 8'h00;
                endcase
            end
            clr = bus_wr && bus_addr == 3'd5 && bus_wdata[0];
            if (clr) m_flag = 0;
            else if (m_ien && now_miss && !m_lvl) m_flag = 1;
            m_lvl = now_miss;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_exp[0] = bus_wdata;
                    3'd1: m_msk[0] = bus_wdata;
                    3'd2: m_exp[1] = bus_wdata;
                    3'd3: m_msk[1] = bus_wdata;
                    3'd4: begin m_ien = bus_wdata[0]; m_wen = bus_wdata[1]; end
                    default: ;
                endcase
            end
            void'(qa.pop_front()); qa.push_back(port_a);
            void'(qb.pop_front()); qb.push_back(port_b);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one clock: sample 1 ns after the edge, compare with the model
    task automatic tick();
        @(posedge clk);
        #1;
        if (rst_n) begin
            chk("R3", "mismatch_o vs model", int'(mismatch), int'(m_lvl));
            chk("R6", "irq_o vs model", int'(irq), int'(m_flag));
            chk("R8", "wake_o vs model", int'(wake), int'(m_wen && m_miss()));
            chk("R2", "rdata vs model", int'(bus_rdata), int'(m_rd));
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, logic [7:0] exp, string req);
        bus_rd = 1; bus_addr = a;
        tick();
        bus_rd = 0;
        chk(req, "readback", int'(bus_rdata), int'(exp));
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1;
        #1;
        chk("R1", "mismatch after reset", int'(mismatch), 0);
        chk("R1", "irq after reset", int'(irq), 0);
        chk("R1", "wake after reset", int'(wake), 0);
        // R1 reset readback
        rd(3'd0, 8'hFF, "R1");
        rd(3'd1, 8'h00, "R1");
        rd(3'd2, 8'hFF, "R1");
        rd(3'd3, 8'h00, "R1");
        rd(3'd4, 8'h00, "R1");
        rd(3'd6, 8'h00, "R2");
        // R2: register write and read back
        wr(3'd1, 8'h0F);
        wr(3'd4, 8'h03);
        rd(3'd1, 8'h0F, "R2");
        rd(3'd4, 8'h03, "R2");
        port_a = 8'hFF; port_b = 8'hFF;
        wait_n(4);
        chk("R3", "no mismatch on matching pins", int'(mismatch), 0);
        // R5: latency of a pin change
        port_a = 8'hFE;
        wait_n(2);
        chk("R5", "wake after two edges", int'(wake), 1);
        chk("R5", "level not yet after two edges", int'(mismatch), 0);
        tick();
        chk("R5", "level after three edges", int'(mismatch), 1);
        chk("R6", "flag set with rising level", int'(irq), 1);
        rd(3'd5, 8'h03, "R2");
        // R7: sticky, then cleared while level stays high
        wait_n(3);
        chk("R7", "flag sticky", int'(irq), 1);
        wr(3'd5, 8'h01);
        chk("R7", "flag cleared", int'(irq), 0);
        wait_n(3);
        chk("R7", "no re-set while level high", int'(irq), 0);
        // R4: masked-out pins ignored
        port_a = 8'hFF;
        wait_n(4);
        chk("R3", "mismatch gone", int'(mismatch), 0);
        port_a = 8'h0F;
        wait_n(4);
        chk("R4", "masked pins no mismatch", int'(mismatch), 0);
        chk("R4", "masked pins no wake", int'(wake), 0);
        chk("R4", "masked pins no irq", int'(irq), 0);
        // R3: group B alone
        wr(3'd3, 8'h80);
        port_b = 8'h7F;
        wait_n(3);
        chk("R3", "group B mismatch", int'(mismatch), 1);
        chk("R6", "group B flag", int'(irq), 1);
        wr(3'd5, 8'h01);
        port_b = 8'hFF;
        wait_n(4);
        chk("R3", "group B restored", int'(mismatch), 0);
        // R10: interrupt disabled, wake still follows
        wr(3'd4, 8'h02);
        port_b = 8'h00;
        wait_n(3);
        chk("R10", "level rises", int'(mismatch), 1);
        chk("R10", "no flag when disabled", int'(irq), 0);
        chk("R8", "wake independent of irq enable", int'(wake), 1);
        wr(3'd4, 8'h01);
        chk("R8", "wake gated off", int'(wake), 0);
        wait_n(2);
        chk("R10", "enable after rise sets nothing", int'(irq), 0);
        port_b = 8'hFF;
        wait_n(4);
        // R9: write-induced mismatch
        wr(3'd0, 8'hF0);
        chk("R9", "level not yet at write edge", int'(mismatch), 0);
        tick();
        chk("R9", "level after write", int'(mismatch), 1);
        chk("R9", "flag from write", int'(irq), 1);
        wr(3'd5, 8'h01);
        wr(3'd0, 8'h0F);
        wait_n(2);
        chk("R9", "match restored", int'(mismatch), 0);
        // R7: clear on the same edge as a set
        wr(3'd2, 8'h00);
        wr(3'd5, 8'h01);
        chk("R7", "level rose at clear edge", int'(mismatch), 1);
        chk("R7", "clear wins over set", int'(irq), 0);
        wait_n(3);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule